// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects interrupt requests from up to 31 peripheral sources and routes them to a small set of targets, called contexts. Each source passes through its own gateway, which can be set to level or edge mode. The gateway turns a request into a pending bit and then blocks further requests from that source until the source is released. Each source has a priority. Each context has its own enable bitmap and its own priority threshold, and drives one interrupt line.

A context services an interrupt in two steps. It reads its claim register, which returns the winning source ID and clears that source's pending bit in the same access. When it has finished, it writes that ID back to release the source. A request is offered to every context that has it enabled. The first context to claim it takes it, and a later claimant gets 0. Software can also raise a pending bit directly.

All configuration goes through a plain 32-bit register bus. The bus accepts one access in any cycle in which `bus_valid` is high and never applies back-pressure. Exactly one cycle after each access, `rsp_valid` is high. For a read, `rsp_rdata` then holds the data; for a write it holds 0. ID 0 is reserved, and `N_SRC` is at most 32, so every bitmap fits in one word.

Top module: `plic_core`

## Requirements
- R1: After reset, all priorities, enables, thresholds, trigger types and pending bits are 0, no source is in service, `ctx_irq` is all low, and a claim read returns 0.
- R2: The priority of source ID is at address 4*ID and is `PRIO_W` bits wide; wider write data is truncated. ID 0 always reads 0 and ignores writes.
- R3: The enable bitmap of context c is at 0x2000 + c*0x80, with bit n enabling ID n, and bit 0 always reads 0. The threshold of context c is at 0x200000 + c*0x1000.
- R4: `ctx_irq[c]` is high exactly when some source is pending, enabled for c, and has a priority strictly greater than c's threshold. A source with priority 0 never interrupts, and a priority equal to the threshold does not interrupt.
- R5: A read of 0x200004 + c*0x1000 returns the ID of the pending, enabled, nonzero-priority source with the highest priority; on equal priority the lower ID wins. The threshold does not affect this choice. The read clears that source's pending bit and puts the source in service. If no source qualifies, it returns 0.
- R6: Once one context has claimed a source, a claim read by another context that also enables it returns 0, unless a different source qualifies for that context.
- R7: In level mode (trigger bit 0), a high input sets pending. While the source is in service, the input sets nothing. After completion, an input that is still high sets pending again.
- R8: The trigger-type word is at 0x1080, with bit n = 1 selecting edge mode for ID n; bit 0 reads 0. In edge mode, a rising input edge sets pending, and a steady high level does not. An edge that arrives after completion is captured even if the source has not yet been serviced. An edge that arrives while the source is in service is dropped.
- R9: Writing an ID to the claim address completes it and takes the source out of service. A write whose value is not the ID of an in-service source is ignored; this includes values of `N_SRC` or more.
- R10: The pending word is at 0x1000, with bit n for ID n. Writing 1 to a bit sets that pending bit, and writing 0 clears nothing.
- R11: A read of an unmapped address returns 0, and a write to one changes nothing. `rsp_valid` is high exactly in the cycle after an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | N_SRC | Source request lines; bit 0 unused |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| ctx_irq | output | N_CTX | Interrupt line per context |

## Verification
A corrupted pending or in-service flag appears at the ports within one or two cycles. It shows as a pending word read that differs from the stimulus history, or as a claim that returns the wrong ID or a stale ID. A lost in-service flag is exposed by a level source that is still held high: it re-pends at once, before any completion. A faulty priority compare surfaces at `ctx_irq` in the same cycle as the state change. It is probed with ties, equal-to-threshold cases and priority-0 sources.

// File: rtl/plic_pkg.sv
`timescale 1ns/1ps
package plic_pkg;
  localparam logic [31:0] PEND_ADDR   = 32'h0000_1000;
  localparam logic [31:0] TRIG_ADDR   = 32'h0000_1080;
  localparam logic [31:0] EN_BASE     = 32'h0000_2000;
  localparam int          EN_STRIDE   = 32'h80;
  localparam logic [31:0] CTX_BASE    = 32'h0020_0000;
  localparam int          CTX_STRIDE  = 32'h1000;
  localparam logic [11:0] CLAIM_OFF   = 12'h004;

  typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;
endpackage

// File: rtl/plic_gateway.sv
`timescale 1ns/1ps
module plic_gateway
  import plic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  irq,
  input  trig_e mode,
  input  logic  sw_set,
  input  logic  claim,
  input  logic  done,
  output logic  pend,
  output logic  busy
);
  logic prev;
  logic req;

  assign req = (mode == TRIG_EDGE) ? (irq & ~prev) : irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pend <= 1'b0;
      busy <= 1'b0;
    end else begin
      prev <= irq;
      if (claim)                     pend <= 1'b0;
      else if ((req && !busy) || sw_set) pend <= 1'b1;
      if (claim)     busy <= 1'b1;
      else if (done) busy <= 1'b0;
    end
  end

  // R5: a claimed source leaves the pending array and enters service
  a_r5_claim_takes: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> (busy && !pend));
  // R7: hardware requests are held off while in service
  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !sw_set && !pend) |=> !pend);
  // R9: completion releases the source
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !claim) |=> !busy);
endmodule

// File: rtl/plic_pick.sv
`timescale 1ns/1ps
module plic_pick #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [N_SRC-1:0]             cand,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output logic [ID_W-1:0]              best_id,
  output logic [PRIO_W-1:0]            best_pr
);
  // Strict greater-than keeps the lowest ID on a tie; starting at 0 drops priority-0 sources.
  always_comb begin
    best_id = '0;
    best_pr = '0;
    for (int i = 1; i < N_SRC; i++) begin
      if (cand[i] && (prio[i] > best_pr)) begin
        best_id = ID_W'(i);
        best_pr = prio[i];
      end
    end
  end
endmodule

// File: rtl/plic_core.sv
`timescale 1ns/1ps
module plic_core
  import plic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_irq,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [N_CTX-1:0]  ctx_irq
);
  localparam int ID_W  = $clog2(N_SRC);
  localparam int CTX_W = $clog2(N_CTX);

  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [N_CTX-1:0][N_SRC-1:0]  en;
  logic [N_CTX-1:0][PRIO_W-1:0] thr;
  logic [N_SRC-1:0]             trig;
  logic [N_SRC-1:0]             pend, busy;
  logic [N_SRC-1:0]             claim_vec, done_vec, sw_vec;
  logic [N_CTX-1:0][ID_W-1:0]   best_id;
  logic [N_CTX-1:0][PRIO_W-1:0] best_pr;

  // ---------------- address decode ----------------
  logic [31:0]      a32;
  logic             prio_hit, pend_hit, trig_hit, en_hit, ctx_hit, thr_hit, clm_hit;
  logic [ID_W-1:0]  pid;
  logic [CTX_W-1:0] ectx, cctx;
  logic             wr, rd, clm_rd, clm_wr;

  assign a32      = 32'(bus_addr);
  assign prio_hit = (a32 < 32'(4*N_SRC)) && (a32[1:0] == 2'b00);
  assign pend_hit = (a32 == PEND_ADDR);
  assign trig_hit = (a32 == TRIG_ADDR);
  assign en_hit   = (a32 >= EN_BASE) && (a32 < EN_BASE + 32'(N_CTX*EN_STRIDE))
                    && (a32[6:0] == 7'd0);
  assign ctx_hit  = (a32 >= CTX_BASE) && (a32 < CTX_BASE + 32'(N_CTX*CTX_STRIDE));
  assign thr_hit  = ctx_hit && (a32[11:0] == 12'd0);
  assign clm_hit  = ctx_hit && (a32[11:0] == CLAIM_OFF);
  assign pid      = a32[ID_W+1:2];
  assign ectx     = a32[CTX_W+6:7];
  assign cctx     = a32[CTX_W+11:12];
  assign wr       = bus_valid && bus_write;
  assign rd       = bus_valid && !bus_write;
  assign clm_rd   = rd && clm_hit;
  assign clm_wr   = wr && clm_hit;

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio <= '0;
      en   <= '0;
      thr  <= '0;
      trig <= '0;
    end else if (wr) begin
      if (prio_hit && (pid != '0)) prio[pid] <= bus_wdata[PRIO_W-1:0];
      if (trig_hit) trig <= {bus_wdata[N_SRC-1:1], 1'b0};
      if (en_hit)   en[ectx] <= {bus_wdata[N_SRC-1:1], 1'b0};
      if (thr_hit)  thr[cctx] <= bus_wdata[PRIO_W-1:0];
    end
  end

  // ---------------- gateways ----------------
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i == 0) begin : g_reserved
      logic unused_src0;
      assign unused_src0  = src_irq[0];
      assign claim_vec[0] = 1'b0;
      assign done_vec[0]  = 1'b0;
      assign sw_vec[0]    = 1'b0;
      assign pend[0]      = 1'b0;
      assign busy[0]      = 1'b0;
    end else begin : g_gate
      assign claim_vec[i] = clm_rd && (best_id[cctx] == ID_W'(i));
      assign done_vec[i]  = clm_wr && (bus_wdata == 32'(i)) && busy[i];
      assign sw_vec[i]    = wr && pend_hit && bus_wdata[i];
      plic_gateway u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq    (src_irq[i]),
        .mode   (trig_e'(trig[i])),
        .sw_set (sw_vec[i]),
        .claim  (claim_vec[i]),
        .done   (done_vec[i]),
        .pend   (pend[i]),
        .busy   (busy[i])
      );
    end
  end

  // ---------------- per-context arbitration ----------------
  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    plic_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
      .cand    (pend & en[c]),
      .prio    (prio),
      .best_id (best_id[c]),
      .best_pr (best_pr[c])
    );
    assign ctx_irq[c] = (best_pr[c] > thr[c]);

    // R4: an interrupt line never rises without an enabled pending source
    a_r4_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_irq[c] |-> |(pend & en[c]));
  end

  // ---------------- read path ----------------
  logic [31:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    if (prio_hit)      rdata_d = 32'(prio[pid]);
    else if (pend_hit) rdata_d = 32'(pend);
    else if (trig_hit) rdata_d = 32'(trig);
    else if (en_hit)   rdata_d = 32'(en[ectx]);
    else if (thr_hit)  rdata_d = 32'(thr[cctx]);
    else if (clm_hit)  rdata_d = 32'(best_id[cctx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid;
      rsp_rdata <= rd ? rdata_d : 32'd0;
    end
  end

  // R11: every access is answered on the next cycle
  a_r11_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);
  // R9: a completion value that names no source leaves service state untouched
  a_r9_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (clm_wr && (bus_wdata >= 32'(N_SRC))) |=> $stable(busy));
  // R5: a claim read leaves at most one source newly in service
  a_r5_one_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));
endmodule

// File: tb/tb_plic_core.sv
`timescale 1ns/1ps
module tb_plic_core;
  localparam int N_SRC = 32;
  localparam int N_CTX = 2;
  localparam int AW    = 22;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_SRC-1:0]  src_irq = '0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [N_CTX-1:0]  ctx_irq;

  int total = 0;
  int bad   = 0;
  logic last_rv;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  plic_core dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ctx_irq(ctx_irq)
  );

  localparam logic [AW-1:0] PEND = 22'h001000;
  localparam logic [AW-1:0] TRIG = 22'h001080;
  localparam logic [AW-1:0] EN0  = 22'h002000;
  localparam logic [AW-1:0] EN1  = 22'h002080;
  localparam logic [AW-1:0] THR0 = 22'h200000;
  localparam logic [AW-1:0] THR1 = 22'h201000;
  localparam logic [AW-1:0] CLM0 = 22'h200004;
  localparam logic [AW-1:0] CLM1 = 22'h201004;

  typedef struct packed {
    logic        wr;
    logic [21:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 22'h00000C, 32'd5,          32'd0},          // R2 write prio of ID 3
    '{1'b0, 22'h00000C, 32'd0,          32'd5},          // R2 readback
    '{1'b1, 22'h000010, 32'hF,          32'd0},          // R2 write over-wide prio
    '{1'b0, 22'h000010, 32'd0,          32'd7},          // R2 truncated to 3 bits
    '{1'b1, 22'h000000, 32'd7,          32'd0},          // R2 ID 0 write
    '{1'b0, 22'h000000, 32'd0,          32'd0},          // R2 ID 0 reads 0
    '{1'b1, 22'h002000, 32'hFFFF_FFFF,  32'd0},          // R3 enable ctx 0
    '{1'b0, 22'h002000, 32'd0,          32'hFFFF_FFFE},  // R3 bit 0 forced low
    '{1'b1, 22'h201000, 32'd1,          32'd0},          // R3 threshold ctx 1
    '{1'b0, 22'h201000, 32'd0,          32'd1},          // R3 readback
    '{1'b0, 22'h000080, 32'd0,          32'd0},          // R11 past last prio
    '{1'b1, 22'h001080, 32'h5,          32'd0},          // R8 trigger write
    '{1'b0, 22'h001080, 32'd0,          32'h4}           // R8 bit 0 forced low
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [AW-1:0] ad, input logic [31:0] wd,
                     output logic [31:0] rdo);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = ad; bus_wdata = wd;
    @(posedge clk);
    #1;
    rdo = rsp_rdata;
    last_rv = rsp_valid;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr32(input logic [AW-1:0] ad, input logic [31:0] wd);
    logic [31:0] d;
    acc(1'b1, ad, wd, d);
  endtask

  task automatic rd32(input logic [AW-1:0] ad, output logic [31:0] rdo);
    acc(1'b0, ad, 32'd0, rdo);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_irq = '0; bus_valid = 1'b0;
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 irq low", 32'(ctx_irq), 32'd0);
    rd32(CLM0, r);            check("R1 claim empty", r, 32'd0);
    rd32(22'h00000C, r);      check("R1 prio zero", r, 32'd0);
    rd32(PEND, r);            check("R1 pending zero", r, 32'd0);
    rd32(EN1, r);             check("R1 enable zero", r, 32'd0);

    // table of register vectors (R2, R3, R8, R11)
    for (int k = 0; k < NV; k++) begin
      acc(VEC[k].wr, VEC[k].addr, VEC[k].wd, r);
      if (!VEC[k].wr) check($sformatf("table vector %0d", k), r, VEC[k].exp);
    end

    // ---- level sources, priority, threshold, claims (R4 R5 R7) ----
    do_reset();
    wr32(22'h00000C, 5); wr32(22'h000014, 5); wr32(22'h000018, 2);
    wr32(EN0, 32'h68); wr32(THR0, 4);
    @(negedge clk) src_irq[6] = 1'b1;
    idle(2);
    check("R4 low prio below threshold", 32'(ctx_irq[0]), 0);
    @(negedge clk) begin src_irq[3] = 1'b1; src_irq[5] = 1'b1; end
    idle(2);
    check("R4 above threshold", 32'(ctx_irq[0]), 1);
    rd32(CLM0, r);  check("R5 tie lower ID", r, 3);
    rd32(PEND, r);  check("R7 held off in service", r, 32'h60);
    rd32(CLM0, r);  check("R5 next", r, 5);
    rd32(CLM0, r);  check("R5 below threshold still claimable", r, 6);
    rd32(CLM0, r);  check("R5 empty gives 0", r, 0);
    check("R4 nothing pending", 32'(ctx_irq[0]), 0);
    wr32(CLM0, 3);
    idle(1);
    rd32(PEND, r);  check("R7 re-pend after completion", r, 32'h08);
    // R9 bogus completion: 37 aliases ID 5 in low bits
    wr32(CLM0, 37);
    idle(1);
    rd32(PEND, r);  check("R9 out of range ignored", r, 32'h08);
    wr32(CLM0, 5);
    idle(1);
    rd32(PEND, r);  check("R9 valid completion", r, 32'h28);
    wr32(THR0, 5);
    idle(1);
    check("R4 equal to threshold", 32'(ctx_irq[0]), 0);

    // ---- multicast and software pending (R6 R10) ----
    do_reset();
    wr32(22'h000024, 3); wr32(EN0, 32'h200); wr32(EN1, 32'h200);
    wr32(PEND, 32'h200);
    idle(1);
    rd32(PEND, r);  check("R10 software set", r, 32'h200);
    check("R6 both contexts signalled", 32'(ctx_irq), 32'h3);
    rd32(CLM1, r);  check("R6 first claimant", r, 9);
    check("R6 lines drop", 32'(ctx_irq), 0);
    rd32(CLM0, r);  check("R6 later claimant gets 0", r, 0);
    wr32(PEND, 32'h400);
    wr32(PEND, 32'h0);
    idle(1);
    rd32(PEND, r);  check("R10 zero write clears nothing", r, 32'h400);
    wr32(EN0, 32'h600);
    idle(1);
    check("R4 priority 0 never interrupts", 32'(ctx_irq[0]), 0);
    rd32(CLM0, r);  check("R5 priority 0 not claimable", r, 0);

    // ---- edge sources (R8) ----
    do_reset();
    wr32(TRIG, 32'h1000); wr32(22'h000030, 1); wr32(EN0, 32'h1000);
    @(negedge clk) src_irq[12] = 1'b1;
    idle(2);
    rd32(PEND, r);  check("R8 rising edge pends", r, 32'h1000);
    check("R8 irq raised", 32'(ctx_irq[0]), 1);
    rd32(CLM0, r);  check("R8 claim edge source", r, 12);
    wr32(CLM0, 12);
    idle(2);
    rd32(PEND, r);  check("R8 steady high no pend", r, 0);
    @(negedge clk) src_irq[12] = 1'b0;
    idle(1);
    @(negedge clk) src_irq[12] = 1'b1;
    idle(2);
    rd32(PEND, r);  check("R8 edge after early completion kept", r, 32'h1000);
    rd32(CLM0, r);  check("R8 claim again", r, 12);
    @(negedge clk) src_irq[12] = 1'b0;
    idle(1);
    @(negedge clk) src_irq[12] = 1'b1;
    idle(2);
    rd32(PEND, r);  check("R8 edge in service dropped", r, 0);
    wr32(CLM0, 12);
    idle(2);
    rd32(PEND, r);  check("R8 nothing after completion", r, 0);

    // ---- unmapped space and response timing (R11) ----
    wr32(22'h003000, 32'hFFFF_FFFF);
    check("R11 response valid", 32'(last_rv), 1);
    idle(1);
    check("R11 no response when idle", 32'(rsp_valid), 0);
    rd32(22'h1FFFFC, r);  check("R11 unmapped read", r, 0);
    rd32(EN0, r);         check("R11 unmapped write no effect", r, 32'h1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule